// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside the retire stage of a simple in-order core and decides when the core drops into debug mode and when it leaves. There are four kinds of entry request. The first is a debug interrupt, which comes from an external pin or from the test port and is held until taken. The others are a software breakpoint instruction at retire, a hardware breakpoint hit flagged on the retiring instruction, and single-step. A fixed priority merges these into a single entry path. An entry is taken only on a cycle where an instruction retires outside debug mode. The controller then sends the core to a fixed handler address, stores a return PC, and records the winning source as a one-hot cause.

Debug mode ends only when the debug-return instruction retires while the core is in debug mode. The controller then sends the core back to the stored return PC. A boot-mode input can place the core in debug mode straight out of reset. A small register port lets the debug handler read and write the return PC and a scratch word. Through the same port the handler reads a status word and sets or clears the single-step enable.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset with `boot_dbg`=0, `in_debug`=0, `redirect_valid`=0, and the status and return-PC registers read 0. After reset with `boot_dbg`=1, `in_debug`=1, the status cause reads debug interrupt (status = 0x11), and the return PC reads `RESET_PC` (default 0xBFC00000).
- R2: A retiring breakpoint instruction (`ret_brk`) outside debug mode has the following effect on the next cycle: `redirect_valid` pulses high for exactly one cycle with `redirect_pc`=`HANDLER_PC` (default 0xFF200200), `in_debug` rises, the return PC equals that instruction's `ret_pc`, and status cause bit 3 is set.
- R3: A retiring instruction flagged with `hw_bp_hit` outside debug mode enters debug mode the same way as R2, with return PC = `ret_pc` and status cause bit 2.
- R4: A debug interrupt from either `ext_dint` or `tap_dint` is latched as pending (status bit 5). It is taken at the next retire outside debug mode, with return PC = `ret_pc` of that squashed instruction and status cause bit 4. Pending is cleared when it is taken.
- R5: While the single-step enable (status bit 8) is set, the first instruction that retires outside debug mode causes entry with status cause bit 1 and return PC = `ret_pc` + `INSN_BYTES` (default 4).
- R6: When several sources are present on the same retire, the order of precedence is interrupt, then breakpoint instruction, then hardware breakpoint, then single-step. The cause field (status bits 4:1) holds only the winner.
- R7: While in debug mode, breakpoint instructions and hardware breakpoint hits are ignored: there is no redirect, `in_debug` stays high, and the return PC and cause do not change.
- R8: A debug interrupt that arrives in debug mode stays pending across the return and is taken at the first retire after it.
- R9: A debug-return instruction (`ret_dret`) retiring in debug mode produces, on the next cycle, a one-cycle redirect to the stored return PC, and `in_debug` falls. Outside debug mode, `ret_dret` is ignored.
- R10: Register port: `reg_sel`=0 selects the return PC (read/write), 1 selects status (only bit 8 is writable; bit 0 is in-debug), 2 selects scratch (read/write), and 3 reads 0 and ignores writes.
- R11: A retire outside debug mode with no source active and step disabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_dbg | input | 1 | Sampled in reset: start in debug mode |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | AW | PC of the retiring instruction |
| ret_brk | input | 1 | Retiring instruction is the debug breakpoint |
| ret_dret | input | 1 | Retiring instruction is the debug return |
| hw_bp_hit | input | 1 | Hardware breakpoint matched the retiring instruction |
| ext_dint | input | 1 | Debug interrupt from the external pin |
| tap_dint | input | 1 | Debug interrupt request from the test port |
| reg_sel | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for `reg_sel` |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | AW | Redirect target |
| in_debug | output | 1 | Core is in debug mode |

## Verification
Entry is driven once by each source on its own. This shows that each source produces its own cause bit and return-PC rule; single-step is the only source that saves the next address. The sources are then driven together in pairs (breakpoint with hardware hit, hardware hit with step, breakpoint with interrupt), which shows that precedence is applied and not a merge. Breakpoints and returns are also applied in the mode where they must be ignored, and interrupts are pulsed with no retire and inside debug mode, which separates a pending request from an immediate one. A scoreboard matches every redirect to its expected target, so a missing, extra or stretched pulse is detected.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [1:0] {
        SEL_RETPC   = 2'd0,
        SEL_STATUS  = 2'd1,
        SEL_SCRATCH = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    // One-hot cause, MSB first so that it packs into status bits 4:1
    typedef struct packed {
        logic dint;
        logic brk;
        logic hwbp;
        logic step;
    } cause_t;

    typedef struct packed {
        logic   take;
        cause_t cause;
        logic   use_next;
    } entry_t;

    localparam int NSRC        = 4;
    localparam int ST_W        = 16;
    localparam int ST_DMODE    = 0;
    localparam int ST_CAUSE_LO = 1;
    localparam int ST_PEND     = 5;
    localparam int ST_STEP     = 8;

    function automatic logic [ST_W-1:0] pack_status(
        input logic   dmode,
        input cause_t cause,
        input logic   pend,
        input logic   step_on
    );
        logic [ST_W-1:0] w;
        w = '0;
        w[ST_DMODE] = dmode;
        w[ST_CAUSE_LO +: 4] = cause;
        w[ST_PEND] = pend;
        w[ST_STEP] = step_on;
        return w;
    endfunction

    function automatic cause_t grant_to_cause(input logic [NSRC-1:0] g);
        cause_t c;
        c.dint = g[0];
        c.brk  = g[1];
        c.hwbp = g[2];
        c.step = g[3];
        return c;
    endfunction

endpackage

// File: rtl/dbg_src_arb.sv
module dbg_src_arb
    import dbg_pkg::*;
#(
    parameter int AW         = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic          dmode,
    input  logic          ret_valid,
    input  logic [AW-1:0] ret_pc,
    input  logic          irq_req,
    input  logic          brk_req,
    input  logic          hw_req,
    input  logic          step_on,
    output entry_t        ent,
    output logic [AW-1:0] save_pc
);
    logic [NSRC-1:0] req;
    logic [NSRC-1:0] grant;
    logic            open_slot;

    // Index 0 wins: interrupt, breakpoint, hardware hit, step
    assign open_slot = ret_valid & ~dmode;
    assign req = {step_on, hw_req, brk_req, irq_req} & {NSRC{open_slot}};

    always_comb begin
        logic found;
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        ent.take     = |grant;
        ent.cause    = grant_to_cause(grant);
        ent.use_next = grant[NSRC-1];
        save_pc      = ent.use_next ? (ret_pc + AW'(INSN_BYTES)) : ret_pc;
    end
endmodule

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl
    import dbg_pkg::*;
#(
    parameter int          AW         = 32,
    parameter logic [31:0] HANDLER_PC = 32'hFF20_0200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boot_dbg,
    input  entry_t        ent,
    input  logic          dret_fire,
    input  logic          irq_in,
    input  logic [AW-1:0] retpc_q,
    output logic          dmode_q,
    output logic          pend_q,
    output logic          redir_v_q,
    output logic [AW-1:0] redir_pc_q
);
    logic irq_taken;
    assign irq_taken = ent.take & ent.cause.dint;

    always_ff @(posedge clk) begin
        if (rst) begin
            dmode_q    <= boot_dbg;
            pend_q     <= 1'b0;
            redir_v_q  <= 1'b0;
            redir_pc_q <= '0;
        end else begin
            redir_v_q <= 1'b0;
            pend_q    <= (pend_q | irq_in) & ~irq_taken;
            if (ent.take) begin
                dmode_q    <= 1'b1;
                redir_v_q  <= 1'b1;
                redir_pc_q <= AW'(HANDLER_PC);
            end else if (dret_fire) begin
                dmode_q    <= 1'b0;
                redir_v_q  <= 1'b1;
                redir_pc_q <= retpc_q;
            end
        end
    end
endmodule

// File: rtl/dbg_ctx_regs.sv
module dbg_ctx_regs
    import dbg_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [31:0] RESET_PC = 32'hBFC0_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boot_dbg,
    input  entry_t        ent,
    input  logic [AW-1:0] save_pc,
    input  logic          dmode,
    input  logic          pend,
    input  logic [1:0]    reg_sel,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic [AW-1:0] retpc_q,
    output cause_t        cause_q,
    output logic          step_q
);
    logic [AW-1:0]   scratch_q;
    logic [ST_W-1:0] status_w;
    reg_sel_e        sel;
    cause_t          boot_cause;

    assign sel = reg_sel_e'(reg_sel);

    always_comb begin
        boot_cause      = '0;
        boot_cause.dint = boot_dbg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            retpc_q   <= boot_dbg ? AW'(RESET_PC) : '0;
            cause_q   <= boot_cause;
            scratch_q <= '0;
            step_q    <= 1'b0;
        end else begin
            if (ent.take) begin
                retpc_q <= save_pc;
                cause_q <= ent.cause;
            end else if (reg_we && sel == SEL_RETPC) begin
                retpc_q <= reg_wdata;
            end
            if (reg_we && sel == SEL_SCRATCH) scratch_q <= reg_wdata;
            if (reg_we && sel == SEL_STATUS)  step_q    <= reg_wdata[ST_STEP];
        end
    end

    assign status_w = pack_status(dmode, cause_q, pend, step_q);

    always_comb begin
        case (sel)
            SEL_RETPC:   reg_rdata = retpc_q;
            SEL_STATUS:  reg_rdata = {{(AW-ST_W){1'b0}}, status_w};
            SEL_SCRATCH: reg_rdata = scratch_q;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
    import dbg_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] HANDLER_PC = 32'hFF20_0200,
    parameter logic [31:0] RESET_PC   = 32'hBFC0_0000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boot_dbg,
    input  logic          ret_valid,
    input  logic [AW-1:0] ret_pc,
    input  logic          ret_brk,
    input  logic          ret_dret,
    input  logic          hw_bp_hit,
    input  logic          ext_dint,
    input  logic          tap_dint,
    input  logic [1:0]    reg_sel,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_pc,
    output logic          in_debug
);
    logic          dmode_q;
    logic          pend_q;
    logic          step_q;
    logic [AW-1:0] retpc_q;
    cause_t        cause_q;
    entry_t        ent;
    logic [AW-1:0] save_pc;
    logic          irq_in;
    logic          dret_fire;

    assign irq_in    = ext_dint | tap_dint;
    assign dret_fire = ret_valid & ret_dret & dmode_q;

    dbg_src_arb #(.AW(AW), .INSN_BYTES(INSN_BYTES)) u_arb (
        .dmode     (dmode_q),
        .ret_valid (ret_valid),
        .ret_pc    (ret_pc),
        .irq_req   (pend_q | irq_in),
        .brk_req   (ret_brk),
        .hw_req    (hw_bp_hit),
        .step_on   (step_q),
        .ent       (ent),
        .save_pc   (save_pc)
    );

    dbg_mode_ctl #(.AW(AW), .HANDLER_PC(HANDLER_PC)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .boot_dbg   (boot_dbg),
        .ent        (ent),
        .dret_fire  (dret_fire),
        .irq_in     (irq_in),
        .retpc_q    (retpc_q),
        .dmode_q    (dmode_q),
        .pend_q     (pend_q),
        .redir_v_q  (redirect_valid),
        .redir_pc_q (redirect_pc)
    );

    dbg_ctx_regs #(.AW(AW), .RESET_PC(RESET_PC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .boot_dbg  (boot_dbg),
        .ent       (ent),
        .save_pc   (save_pc),
        .dmode     (dmode_q),
        .pend      (pend_q),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .retpc_q   (retpc_q),
        .cause_q   (cause_q),
        .step_q    (step_q)
    );

    assign in_debug = dmode_q;
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
    parameter int          AW         = 32,
    parameter logic [31:0] HANDLER_PC = 32'hFF20_0200
) (
    input logic          clk,
    input logic          rst,
    input logic          ret_valid,
    input logic          ret_dret,
    input logic          redirect_valid,
    input logic [AW-1:0] redirect_pc,
    input logic          in_debug,
    input logic [AW-1:0] retpc,
    input logic          pend,
    input logic [3:0]    cause
);
    AST_REDIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |=> !redirect_valid);  // R2

    AST_ENTRY_TO_HANDLER: assert property (@(posedge clk) disable iff (rst)
        $rose(in_debug) |-> (redirect_valid && redirect_pc == AW'(HANDLER_PC)));  // R2

    AST_EXIT_TO_RETPC: assert property (@(posedge clk) disable iff (rst)
        $fell(in_debug) |-> (redirect_valid && redirect_pc == $past(retpc)));  // R9

    AST_REDIRECT_ON_MODE_CHANGE: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (in_debug != $past(in_debug)));  // R9

    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause));  // R6

    AST_STAY_IN_DEBUG: assert property (@(posedge clk) disable iff (rst)
        (in_debug && !(ret_valid && ret_dret)) |=> in_debug);  // R7

    AST_PEND_HELD_IN_DEBUG: assert property (@(posedge clk) disable iff (rst)
        (pend && in_debug) |=> pend);  // R8
endmodule

bind dbg_entry_ctrl dbg_entry_chk #(.AW(AW), .HANDLER_PC(HANDLER_PC)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ret_valid      (ret_valid),
    .ret_dret       (ret_dret),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .in_debug       (in_debug),
    .retpc          (retpc_q),
    .pend           (pend_q),
    .cause          (cause_q)
);

// File: tb/dbg_entry_ctrl_tb.sv
module dbg_entry_ctrl_tb;
    localparam logic [31:0] HPC = 32'hFF20_0200;
    localparam logic [31:0] RPC = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_dbg = 1'b0;
    logic        ret_valid = 1'b0, ret_brk = 1'b0, ret_dret = 1'b0, hw_bp_hit = 1'b0;
    logic        ext_dint = 1'b0, tap_dint = 1'b0, reg_we = 1'b0;
    logic [31:0] ret_pc = '0, reg_wdata = '0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_rdata, redirect_pc;
    logic        redirect_valid, in_debug;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [31:0] expq[$];

    always #4 clk = ~clk;

    dbg_entry_ctrl u_dut (
        .clk(clk), .rst(rst), .boot_dbg(boot_dbg),
        .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_brk(ret_brk), .ret_dret(ret_dret),
        .hw_bp_hit(hw_bp_hit), .ext_dint(ext_dint), .tap_dint(tap_dint),
        .reg_sel(reg_sel), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .in_debug(in_debug)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: every redirect must match the next expected target
    always @(negedge clk) begin
        if (!rst && redirect_valid && !done) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R2/R9 unexpected redirect: actual 0x%08h expected none", redirect_pc);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                if (redirect_pc !== e) begin
                    errors++;
                    $display("FAIL R2/R9 redirect target: actual 0x%08h expected 0x%08h", redirect_pc, e);
                end
            end
        end
    end

    task automatic do_reset(input logic boot);
        @(negedge clk);
        rst = 1'b1; boot_dbg = boot;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic retire(input logic [31:0] pc, input logic brk, input logic hw,
                          input logic dret, input logic ext, input logic tap,
                          input logic exp_redir, input logic [31:0] exp_pc);
        @(negedge clk);
        ret_valid = 1'b1; ret_pc = pc; ret_brk = brk; hw_bp_hit = hw;
        ret_dret = dret; ext_dint = ext; tap_dint = tap;
        if (exp_redir) expq.push_back(exp_pc);
        @(negedge clk);
        ret_valid = 1'b0; ret_brk = 1'b0; hw_bp_hit = 1'b0;
        ret_dret = 1'b0; ext_dint = 1'b0; tap_dint = 1'b0;
    endtask

    task automatic pulse_irq(input logic ext, input logic tap);
        @(negedge clk);
        ext_dint = ext; tap_dint = tap;
        @(negedge clk);
        ext_dint = 1'b0; tap_dint = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_state(input string tag, input logic dbg,
                             input logic [31:0] st, input logic [31:0] pc);
        logic [31:0] v;
        chk({tag, " in_debug"}, {31'd0, in_debug}, {31'd0, dbg});
        rd(2'd1, v); chk({tag, " status"}, v, st);
        rd(2'd0, v); chk({tag, " retpc"}, v, pc);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        // R1: plain reset
        do_reset(1'b0);
        chk("R1 redirect", {31'd0, redirect_valid}, 32'd0);
        chk_state("R1", 1'b0, 32'h0, 32'h0);

        // R11: retire with nothing active
        retire(32'h80, 0, 0, 0, 0, 0, 0, 0);
        chk_state("R11", 1'b0, 32'h0, 32'h0);

        // R2: breakpoint instruction entry
        retire(32'h100, 1, 0, 0, 0, 0, 1, HPC);
        chk_state("R2", 1'b1, 32'h9, 32'h100);

        // R7: sources ignored in debug mode
        retire(32'h200, 1, 1, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk_state("R7", 1'b1, 32'h9, 32'h100);

        // R10: register port
        wr(2'd2, 32'hCAFE_F00D); rd(2'd2, v); chk("R10 scratch", v, 32'hCAFE_F00D);
        wr(2'd0, 32'h400);       rd(2'd0, v); chk("R10 retpc", v, 32'h400);
        wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R10 sel3", v, 32'h0);
        wr(2'd1, 32'h0000_00FE); rd(2'd1, v); chk("R10 status ro bits", v, 32'h9);

        // R9: return to stored PC, then return outside debug ignored
        retire(32'h240, 0, 0, 1, 0, 0, 1, 32'h400);
        chk_state("R9 exit", 1'b0, 32'h8, 32'h400);
        retire(32'h404, 0, 0, 1, 0, 0, 0, 0);
        @(negedge clk);
        chk_state("R9 stray", 1'b0, 32'h8, 32'h400);

        // R3: hardware breakpoint
        retire(32'h500, 0, 1, 0, 0, 0, 1, HPC);
        chk_state("R3", 1'b1, 32'h5, 32'h500);
        retire(32'h504, 0, 0, 1, 0, 0, 1, 32'h500);

        // R4: interrupt held pending, then taken at a retire
        pulse_irq(1'b1, 1'b0);
        chk_state("R4 pend", 1'b0, 32'h24, 32'h500);
        retire(32'h600, 0, 0, 0, 0, 0, 1, HPC);
        chk_state("R4 taken", 1'b1, 32'h11, 32'h600);

        // R8: interrupt during debug kept across the return
        pulse_irq(1'b0, 1'b1);
        chk_state("R8 pend", 1'b1, 32'h31, 32'h600);
        retire(32'h608, 0, 0, 1, 0, 0, 1, 32'h600);
        chk_state("R8 after ret", 1'b0, 32'h30, 32'h600);
        retire(32'h700, 0, 0, 0, 0, 0, 1, HPC);
        chk_state("R8 taken", 1'b1, 32'h11, 32'h700);
        retire(32'h708, 0, 0, 1, 0, 0, 1, 32'h700);

        // R6: breakpoint beats hardware hit
        retire(32'h800, 1, 1, 0, 0, 0, 1, HPC);
        chk_state("R6 brk>hw", 1'b1, 32'h9, 32'h800);
        retire(32'h808, 0, 0, 1, 0, 0, 1, 32'h800);

        // R6: hardware hit beats step
        wr(2'd1, 32'h100);
        chk_state("R5 step on", 1'b0, 32'h108, 32'h800);
        retire(32'h900, 0, 1, 0, 0, 0, 1, HPC);
        chk_state("R6 hw>step", 1'b1, 32'h105, 32'h900);
        retire(32'h908, 0, 0, 1, 0, 0, 1, 32'h900);

        // R5: single step saves the next address
        retire(32'h900, 0, 0, 0, 0, 0, 1, HPC);
        chk_state("R5 step", 1'b1, 32'h103, 32'h904);
        wr(2'd1, 32'h0);
        retire(32'h910, 0, 0, 1, 0, 0, 1, 32'h904);

        // R6: interrupt beats breakpoint
        retire(32'hA00, 1, 0, 0, 1, 0, 1, HPC);
        chk_state("R6 dint>brk", 1'b1, 32'h11, 32'hA00);

        // R1: boot into debug mode
        do_reset(1'b1);
        chk_state("R1 boot", 1'b1, 32'h11, RPC);
        retire(32'h0, 0, 0, 1, 0, 0, 1, RPC);
        chk_state("R1 boot ret", 1'b0, 32'h10, RPC);

        repeat (3) @(negedge clk);
        chk("R2 queue drained", expq.size(), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule